// File: doc/BRIEF.md
# Clock-Synchronous Serial I/O

This block is a byte-wide serial port of the kind found beside a small microcontroller core. A transfer moves exactly eight bits at once: one bit leaves on the data output and one bit arrives on the data input for every serial clock period. One register holds the outgoing byte and, at the end of the transfer, the incoming byte. A write to that register starts a transfer, and a level interrupt request marks when it is done.

The serial clock comes from one of two places. The block can make it itself by dividing one of two oscillator tick inputs by 4, 16, 32 or 64, and then drive it on the clock pin. It can also follow a clock that arrives on the clock pin from a partner device. In that case a synchronizer chain sits between the pin and the shift logic. A mode register picks the clock source, the oscillator, the divide ratio and whether the byte is shifted least or most significant bit first. The CPU reaches both registers through plain write and read strobes with a one-bit register select.

Top module: `sync_serial_io`

## Requirements
- R1: After reset the clock pin output is high, its output enable is low, the data output is high, the interrupt request is low, and both registers read as 0x00.
- R2: Writes with select 0 go to the mode register. Bits [1:0] pick the divide ratio (0→4, 1→16, 2→32, 3→64). Bit 2 picks the oscillator (0 = tick input A, 1 = tick input B). Bit 3 picks the clock source (1 = internal, 0 = external pin). Bit 5 picks the order (1 = LSB first, 0 = MSB first). Bits 7, 6 and 4 always read 0. A read with select 0 returns the mode register.
- R3: In internal mode the clock pin output is enabled. It stays high while idle and gives exactly 8 low-then-high pulses per transfer. Its period is the divide ratio times the tick spacing. With a tick on every cycle, the interrupt request rises exactly 8×ratio cycles after the data-write edge.
- R4: The data output changes only on a falling serial clock edge. The data input is sampled on the rising edge.
- R5: The bits leave in the selected order: bit 0 first when LSB first, bit 7 first when MSB first.
- R6: A read with select 1 after a transfer returns the 8 received bits. The first bit received lands in bit 0 when LSB first and in bit 7 when MSB first.
- R7: In external mode the output enable is low and the clock pin output stays high. Shifting follows the synchronized edges of the clock pin input, and the interrupt request rises on the 8th rising edge and not before.
- R8: A write with select 1 clears the interrupt request on the next cycle, clears the bit count and loads the new byte. This also holds during a transfer, which then restarts with a full 8 pulses.
- R9: With bit 2 set, the internal clock counts tick input B instead of tick input A.
- R10: The interrupt request stays high until the next data write. Mode writes do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickA | input | 1 | Oscillator A tick enable |
| tickB | input | 1 | Oscillator B tick enable |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 mode, 1 data |
| wrData | input | 8 | Write data |
| rdSel | input | 1 | Read source: 0 mode, 1 data |
| rdData | output | 8 | Read data (combinational) |
| sclkIn | input | 1 | Serial clock from pin (external mode) |
| sclkOut | output | 1 | Serial clock to pin (internal mode) |
| sclkOe | output | 1 | Serial clock pin output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Transfer-complete interrupt request |

## Verification
In internal mode every serial clock edge is one register stage after the prescaler's terminal tick. The n-th edge therefore lands exactly n×ratio/2 ticks after the data-write edge, and the interrupt request rises with the 8th rising edge. The bench samples on falling system clock edges and counts those edges from the write, so it expects the interrupt request at exactly 8×ratio cycles and the fall-to-fall spacing at ratio or 3×ratio cycles. The external clock passes through two synchronizer flops and an edge register before it acts. The bench therefore holds each pin level for six cycles and samples the data output and the interrupt request only after that settling window.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int unsigned MODE_W    = 8;
  localparam int unsigned MAX_RATIO = 64;

  typedef struct packed {
    logic [1:0] rsvdHi;
    logic       lsbFirst;
    logic       rsvdMid;
    logic       internalClk;
    logic       oscSel;
    logic [1:0] divSel;
  } modeT;

  typedef struct packed {
    logic load;       // data register written: load and restart
    logic driveBit;   // serial clock falling: present next bit
    logic sampleBit;  // serial clock rising: shift in data input
  } strobeT;

  function automatic int unsigned divRatio(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return MAX_RATIO;
    endcase
  endfunction

  function automatic modeT cleanMode(input logic [MODE_W-1:0] raw);
    modeT m;
    m = modeT'(raw);
    m.rsvdHi  = '0;
    m.rsvdMid = 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen
  import sio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickA,
  input  logic       tickB,
  input  logic       oscSel,
  input  logic [1:0] divSel,
  input  logic       internalClk,
  input  logic       run,
  input  logic       restart,
  input  logic       sclkIn,
  output logic       riseEdge,
  output logic       fallEdge,
  output logic       sclkOut
);

  localparam int unsigned PRE_W = $clog2(MAX_RATIO / 2);

  logic             selTick;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] halfLimit;
  logic             sclkInt;
  logic             intTerm;
  logic             allowEdge;

  assign selTick   = oscSel ? tickB : tickA;
  assign halfLimit = PRE_W'(divRatio(divSel) / 2 - 1);
  assign allowEdge = run && !restart;
  assign intTerm   = internalClk && allowEdge && selTick && (preCnt == halfLimit);

  // prescaler and internal serial clock phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      sclkInt <= 1'b1;
    end else if (restart || !run || !internalClk) begin
      preCnt  <= '0;
      sclkInt <= 1'b1;
    end else if (selTick) begin
      if (preCnt == halfLimit) begin
        preCnt  <= '0;
        sclkInt <= ~sclkInt;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // external clock synchronizer chain
  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   syncPrev;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[s] <= 1'b1;
        else       syncPipe[s] <= sclkIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[s] <= 1'b1;
        else       syncPipe[s] <= syncPipe[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= 1'b1;
    else       syncPrev <= syncPipe[SYNC_STAGES-1];
  end

  logic extRise;
  logic extFall;

  assign extRise = !internalClk && allowEdge && syncPipe[SYNC_STAGES-1] && !syncPrev;
  assign extFall = !internalClk && allowEdge && !syncPipe[SYNC_STAGES-1] && syncPrev;

  assign riseEdge = (intTerm && !sclkInt) || extRise;
  assign fallEdge = (intTerm && sclkInt) || extFall;
  assign sclkOut  = sclkInt;

endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              riseEdge,
  input  logic              fallEdge,
  output modeT              mode,
  output logic              active,
  output logic              loadNow,
  output strobeT            stb,
  output logic              irq
);

  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0] bitCnt;
  logic             lastBit;
  logic             modeWr;

  assign loadNow = wrEn && wrSel;
  assign modeWr  = wrEn && !wrSel;
  assign lastBit = (bitCnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= '0;
    else if (modeWr) mode <= cleanMode(wrData[MODE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
      irq    <= 1'b0;
    end else if (loadNow) begin
      active <= 1'b1;
      bitCnt <= '0;
      irq    <= 1'b0;
    end else if (active && riseEdge) begin
      bitCnt <= bitCnt + 1'b1;
      if (lastBit) begin
        active <= 1'b0;
        irq    <= 1'b1;
      end
    end
  end

  always_comb begin
    stb.load      = loadNow;
    stb.driveBit  = active && fallEdge && !loadNow;
    stb.sampleBit = active && riseEdge && !loadNow;
  end

endmodule

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic              lsbFirst,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdi,
  output logic [DATA_W-1:0] shiftReg,
  output logic              sdo
);

  logic nextOut;

  assign nextOut = lsbFirst ? shiftReg[0] : shiftReg[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.load) begin
      shiftReg <= wrData;
    end else if (stb.sampleBit) begin
      if (lsbFirst) shiftReg <= {sdi, shiftReg[DATA_W-1:1]};
      else          shiftReg <= {shiftReg[DATA_W-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sdo <= 1'b1;
    else if (stb.driveBit) sdo <= nextOut;
  end

endmodule

// File: rtl/sync_serial_io.sv
module sync_serial_io
  import sio_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickA,
  input  logic              tickB,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sclkOe,
  input  logic              sdi,
  output logic              sdo,
  output logic              irq
);

  modeT              mode;
  strobeT            stb;
  logic              active;
  logic              loadNow;
  logic              riseEdge;
  logic              fallEdge;
  logic [DATA_W-1:0] shiftReg;

  sio_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .riseEdge (riseEdge),
    .fallEdge (fallEdge),
    .mode     (mode),
    .active   (active),
    .loadNow  (loadNow),
    .stb      (stb),
    .irq      (irq)
  );

  sio_clkgen #(.SYNC_STAGES(SYNC_STAGES)) clkgen_i (
    .clk         (clk),
    .rstN        (rstN),
    .tickA       (tickA),
    .tickB       (tickB),
    .oscSel      (mode.oscSel),
    .divSel      (mode.divSel),
    .internalClk (mode.internalClk),
    .run         (active),
    .restart     (loadNow),
    .sclkIn      (sclkIn),
    .riseEdge    (riseEdge),
    .fallEdge    (fallEdge),
    .sclkOut     (sclkOut)
  );

  sio_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .lsbFirst (mode.lsbFirst),
    .wrData   (wrData),
    .sdi      (sdi),
    .shiftReg (shiftReg),
    .sdo      (sdo)
  );

  assign sclkOe = mode.internalClk;
  assign rdData = rdSel ? shiftReg : DATA_W'(mode);

endmodule

// File: rtl/sync_serial_io_chk.sv
module sync_serial_io_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic wrSel,
  input logic sclkOut,
  input logic sclkOe,
  input logic sdo,
  input logic irq
);

  logic [3:0] fallCnt;
  logic       prevSclk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallCnt  <= '0;
      prevSclk <= 1'b1;
    end else begin
      prevSclk <= sclkOut;
      if (wrEn && wrSel)                       fallCnt <= '0;
      else if (sclkOe && prevSclk && !sclkOut) fallCnt <= fallCnt + 1'b1;
    end
  end

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel) |=> !irq);

  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOe && $past(sclkOe) && sclkOut && $past(sclkOut)) |-> $stable(sdo));

  // R3
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOe && $past(sclkOe) && $rose(irq)) |-> $rose(sclkOut));

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && sclkOe) |-> sclkOut);

  // R3
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallCnt <= 4'd8);

endmodule

bind sync_serial_io sync_serial_io_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .sclkOut (sclkOut),
  .sclkOe  (sclkOe),
  .sdo     (sdo),
  .irq     (irq)
);

// File: tb/sync_serial_io_tb_top.sv
module sync_serial_io_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickA = 1'b1;
  logic       tickB;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdSel = 1'b0;
  logic [7:0] rdData;
  logic       sclkIn = 1'b1;
  logic       sclkOut;
  logic       sclkOe;
  logic       sdi = 1'b0;
  logic       sdo;
  logic       irq;

  int cyc = 0;
  int total = 0;
  int errs = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tickB = (cyc % 3 == 0);

  sync_serial_io dut_i (
    .clk(clk), .rstN(rstN), .tickA(tickA), .tickB(tickB),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData),
    .sclkIn(sclkIn), .sclkOut(sclkOut), .sclkOe(sclkOe),
    .sdi(sdi), .sdo(sdo), .irq(irq)
  );

  // {mode, tx, rx}: mode bit3 internal, bit5 LSB first, bit2 osc B, [1:0] ratio
  localparam logic [23:0] VEC [5] = '{
    {8'h08, 8'hA5, 8'h3C},
    {8'h29, 8'h81, 8'h5A},
    {8'h0E, 8'h0F, 8'hF0},
    {8'h2B, 8'h6E, 8'h91},
    {8'h2C, 8'hC7, 8'h1D}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input bit sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input bit sel, output logic [7:0] v);
    @(negedge clk);
    rdSel = sel;
    #1;
    v = rdData;
  endtask

  task automatic runInternal(input logic [7:0] tx, input logic [7:0] rx, input bit lsb,
                             output int pulses, output int sdoErr, output int period,
                             output int latency, output int irqAfterWr);
    bit prev;
    int riseN;
    int firstFall;
    doWrite(1'b1, tx);
    irqAfterWr = irq;
    prev = sclkOut;
    pulses = 0; sdoErr = 0; riseN = 0; firstFall = 0; period = 0; latency = 0;
    while (!irq && latency < 20000) begin
      @(negedge clk);
      latency++;
      if (prev && !sclkOut) begin
        pulses++;
        if (pulses == 1) firstFall = latency;
        else if (pulses == 2) period = latency - firstFall;
        if (pulses <= 8) sdi = lsb ? rx[pulses-1] : rx[8-pulses];
      end
      if (!prev && sclkOut) begin
        if (riseN < 8 && sdo !== (lsb ? tx[riseN] : tx[7-riseN])) sdoErr++;
        riseN++;
      end
      prev = sclkOut;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; errs++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, errs);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int pulses, sdoErr, period, latency, irqAW, extraFalls, ratio;
    bit lsb, oscB;

    // reset state (R1)
    repeat (3) @(negedge clk);
    check(sclkOut === 1'b1 && sclkOe === 1'b0 && sdo === 1'b1 && irq === 1'b0,
          "R1 pins", {sclkOut, sclkOe, sdo, irq}, 4'b1010);
    rstN = 1'b1;
    readReg(1'b0, v); check(v === 8'h00, "R1 mode", v, 8'h00);
    readReg(1'b1, v); check(v === 8'h00, "R1 data", v, 8'h00);

    // reserved bits (R2)
    doWrite(1'b0, 8'hFF);
    readReg(1'b0, v); check(v === 8'h2F, "R2 readback", v, 8'h2F);

    // vector table: internal clock transfers (R3 R4 R5 R6 R9 R10)
    for (int i = 0; i < 5; i++) begin
      doWrite(1'b0, VEC[i][23:16]);
      readReg(1'b0, v); check(v === VEC[i][23:16], "R2 mode", v, VEC[i][23:16]);
      check(sclkOe === 1'b1, "R3 oe", sclkOe, 1);
      lsb   = VEC[i][21];
      oscB  = VEC[i][18];
      ratio = (VEC[i][17:16] == 2'd0) ? 4 : (VEC[i][17:16] == 2'd1) ? 16 :
              (VEC[i][17:16] == 2'd2) ? 32 : 64;
      runInternal(VEC[i][15:8], VEC[i][7:0], lsb, pulses, sdoErr, period, latency, irqAW);
      check(pulses == 8, "R3 pulses", pulses, 8);
      check(sdoErr == 0, "R5 sdo order", sdoErr, 0);
      check(period == (oscB ? 3 * ratio : ratio), "R9 period", period, oscB ? 3 * ratio : ratio);
      if (!oscB) check(latency == 8 * ratio, "R3 latency", latency, 8 * ratio);
      extraFalls = 0;
      for (int k = 0; k < 140; k++) begin
        @(negedge clk);
        if (!sclkOut) extraFalls++;
      end
      check(extraFalls == 0, "R3 idle high", extraFalls, 0);
      readReg(1'b1, v); check(v === VEC[i][7:0], "R6 received", v, VEC[i][7:0]);
      doWrite(1'b0, VEC[i][23:16]);
      check(irq === 1'b1, "R10 irq held", irq, 1);
    end

    // restart during a transfer (R8)
    doWrite(1'b0, 8'h09);
    doWrite(1'b1, 8'h33);
    check(irq === 1'b0, "R8 irq cleared", irq, 0);
    repeat (40) @(negedge clk);
    check(irq === 1'b0, "R8 still busy", irq, 0);
    runInternal(8'hB4, 8'h6C, 1'b0, pulses, sdoErr, period, latency, irqAW);
    check(pulses == 8, "R8 full restart", pulses, 8);
    check(latency == 128, "R8 latency", latency, 128);
    check(sdoErr == 0, "R8 sdo", sdoErr, 0);
    readReg(1'b1, v); check(v === 8'h6C, "R8 received", v, 8'h6C);

    // external clock, LSB first then MSB first (R7 R4 R6)
    for (int pass = 0; pass < 2; pass++) begin
      logic [7:0] tx, rx;
      int bad;
      tx = pass ? 8'h96 : 8'h4D;
      rx = pass ? 8'h2E : 8'hD1;
      lsb = (pass == 0);
      doWrite(1'b0, lsb ? 8'h20 : 8'h00);
      doWrite(1'b1, tx);
      check(sclkOe === 1'b0 && sclkOut === 1'b1, "R7 pin idle", {sclkOe, sclkOut}, 2'b01);
      bad = 0;
      for (int b = 0; b < 8; b++) begin
        @(negedge clk); sclkIn = 1'b0;
        repeat (6) @(negedge clk);
        if (sdo !== (lsb ? tx[b] : tx[7-b])) bad++;
        sdi = lsb ? rx[b] : rx[7-b];
        repeat (6) @(negedge clk);
        if (b == 7) check(irq === 1'b0, "R7 irq not early", irq, 0);
        sclkIn = 1'b1;
        repeat (6) @(negedge clk);
      end
      check(bad == 0, "R4 external sdo", bad, 0);
      check(irq === 1'b1, "R7 irq", irq, 1);
      readReg(1'b1, v); check(v === rx, "R6 external rx", v, rx);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, errs);
    $finish;
  end

endmodule